// File: doc/BRIEF.md
# Boot Strap Latch with Reset-Type Dispatch

This block sits beside the chip's reset controller. It holds the boot strap pin values in a status word and, for each reset request, decides whether the strap pins are sampled again and what the boot processor does next. There are three possible outcomes: run the boot sequence, branch to a stored resume address after hibernation, or stay idle.

Four reset request inputs arrive as single-cycle pulses: power-on, full, normal and local. Power-on and full requests sample the 13 strap pins. A normal request keeps the stored word but still starts a boot. A local request changes neither the word nor the boot state. The stored word is split into three fields: a boot device code, a device configuration field and a clock multiplier field. For the two serial-memory boot devices, the multiplier field is reinterpreted as extra configuration and the PLL is bypassed. The next-action indication is a registered one-hot triple. It is held until the consumer pulses an acknowledge.

Top module: `boot_strap_latch`

## Requirements
- R1: After `rst_n` is deasserted and before any request, `status_word` is 0, `resume_addr` is 0, `act_idle` is 1, and `act_boot` and `act_resume` are 0.
- R2: A cycle with `req_por` high loads `strap_pins` into `status_word`, visible from the next clock edge.
- R3: A cycle with `req_full` high loads `strap_pins` into `status_word`, visible from the next clock edge.
- R4: A normal request with no power-on or full request in the same cycle leaves `status_word` unchanged and raises the boot (or resume) action on the next edge.
- R5: A local request with no other request in the same cycle leaves `status_word` unchanged and puts the action to idle on the next edge.
- R6: `boot_dev` always equals `status_word[2:0]`, and `dev_cfg` always equals `status_word[9:3]`.
- R7: When `boot_dev` is 5 or 6, `pll_bypass` is 1, `ext_cfg` equals `status_word[12:10]` and `pll_sel` is 0. For every other `boot_dev`, `pll_bypass` is 0, `pll_sel` equals `status_word[12:10]` and `ext_cfg` is 0.
- R8: A power-on, full or normal request seen with `hib_flag` high raises `act_resume` on the next edge, with `resume_addr` equal to `hib_addr` from the request cycle. With `hib_flag` low, it raises `act_boot` instead and `resume_addr` is 0.
- R9: When several requests arrive in one cycle, the highest one takes effect in the order power-on, full, normal, local. A local request never cancels a boot or a pin sample made by a higher request in the same cycle.
- R10: The action output holds its value while no request arrives and `ack` is low. An `ack` with no request returns the action to idle. A request in the same cycle as `ack` takes the request's action.
- R11: Exactly one of `act_idle`, `act_boot` and `act_resume` is high in every cycle.
- R12: `resume_addr` is nonzero only while `act_resume` is high, and it stays stable for as long as `act_resume` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| req_por | input | 1 | Power-on reset request pulse |
| req_full | input | 1 | Full reset request pulse |
| req_norm | input | 1 | Normal reset request pulse |
| req_local | input | 1 | Local reset request pulse |
| strap_pins | input | 13 | Boot strap pin levels |
| hib_flag | input | 1 | Hibernation state flag |
| hib_addr | input | 32 | Resume address for hibernation exit |
| ack | input | 1 | Consumer acknowledge of the next action |
| status_word | output | 13 | Stored strap word |
| boot_dev | output | 3 | Boot device code |
| dev_cfg | output | 7 | Device configuration field |
| pll_sel | output | 3 | Clock multiplier selection (0 when bypassed) |
| ext_cfg | output | 3 | Extended configuration (0 when not bypassed) |
| pll_bypass | output | 1 | PLL bypass for serial-memory boot devices |
| act_boot | output | 1 | Next action: run the boot sequence |
| act_resume | output | 1 | Next action: branch to resume_addr |
| act_idle | output | 1 | Next action: stay idle |
| resume_addr | output | 32 | Branch target while resuming |

## Verification
The properties assume that the request inputs, `hib_flag`, `hib_addr` and `ack` are synchronous to `clk` and are settled at each rising edge. They do not assume that requests are one-hot, so any mix of requests may arrive together. The stimulus changes inputs only on the falling edge. It lets several requests coincide freely, and it includes `ack` pulses that land in the same cycle as a request, so the priority and acknowledge rules are exercised rather than avoided.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_LOCAL  = 3'd1,
    RK_NORMAL = 3'd2,
    RK_FULL   = 3'd3,
    RK_POR    = 3'd4
  } rst_kind_e;

  typedef enum logic [2:0] {
    ACT_IDLE   = 3'b001,
    ACT_BOOT   = 3'b010,
    ACT_RESUME = 3'b100
  } action_e;

  // Reset kinds that sample the strap pins again
  function automatic logic kind_latches(rst_kind_e k);
    return (k == RK_POR) || (k == RK_FULL);
  endfunction

  // Reset kinds that start the boot path
  function automatic logic kind_boots(rst_kind_e k);
    return (k == RK_POR) || (k == RK_FULL) || (k == RK_NORMAL);
  endfunction

  // Boot-path outcome given the hibernation flag
  function automatic action_e boot_outcome(logic hib);
    return hib ? ACT_RESUME : ACT_BOOT;
  endfunction

endpackage

// File: rtl/bsl_reset_arbiter.sv
module bsl_reset_arbiter
  import bsl_pkg::*;
(
  input  logic req_por,
  input  logic req_full,
  input  logic req_norm,
  input  logic req_local,
  output logic latch_ev,
  output logic boot_ev,
  output logic local_ev
);

  rst_kind_e kind;

  // Fixed priority: power-on, full, normal, local
  always_comb begin
    if (req_por)        kind = RK_POR;
    else if (req_full)  kind = RK_FULL;
    else if (req_norm)  kind = RK_NORMAL;
    else if (req_local) kind = RK_LOCAL;
    else                kind = RK_NONE;
  end

  assign latch_ev = kind_latches(kind);
  assign boot_ev  = kind_boots(kind);
  assign local_ev = (kind == RK_LOCAL);

endmodule

// File: rtl/bsl_strap_reg.sv
module bsl_strap_reg #(
  parameter int STRAP_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_en,
  input  logic [STRAP_W-1:0] pins,
  output logic [STRAP_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (latch_en) word <= pins;
  end

endmodule

// File: rtl/bsl_field_decode.sv
module bsl_field_decode #(
  parameter int STRAP_W = 13,
  parameter int DEV_W   = 3,
  parameter int PLL_W   = 3,
  parameter int BYP_A   = 5,
  parameter int BYP_B   = 6,
  localparam int CFG_W  = STRAP_W - DEV_W - PLL_W
) (
  input  logic [STRAP_W-1:0] word,
  output logic [DEV_W-1:0]   dev,
  output logic [CFG_W-1:0]   cfg,
  output logic [PLL_W-1:0]   pll_sel,
  output logic [PLL_W-1:0]   ext_cfg,
  output logic               bypass
);

  localparam int PLL_LSB = DEV_W + CFG_W;

  function automatic logic dev_bypasses(logic [DEV_W-1:0] d);
    return (d == DEV_W'(BYP_A)) || (d == DEV_W'(BYP_B));
  endfunction

  logic [PLL_W-1:0] top_field;

  assign dev       = word[DEV_W-1:0];
  assign cfg       = word[PLL_LSB-1:DEV_W];
  assign top_field = word[STRAP_W-1:PLL_LSB];
  assign bypass    = dev_bypasses(dev);
  assign pll_sel   = bypass ? '0 : top_field;
  assign ext_cfg   = bypass ? top_field : '0;

endmodule

// File: rtl/bsl_action_ctrl.sv
module bsl_action_ctrl
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_ev,
  input  logic              local_ev,
  input  logic              hib_flag,
  input  logic [ADDR_W-1:0] hib_addr,
  input  logic              ack,
  output action_e           act,
  output logic [ADDR_W-1:0] addr
);

  action_e           act_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    act_n  = act;
    addr_n = addr;
    if (boot_ev) begin
      act_n  = boot_outcome(hib_flag);
      addr_n = hib_flag ? hib_addr : '0;
    end else if (local_ev || ack) begin
      act_n  = ACT_IDLE;
      addr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= ACT_IDLE;
      addr <= '0;
    end else begin
      act  <= act_n;
      addr <= addr_n;
    end
  end

endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import bsl_pkg::*;
#(
  parameter int STRAP_W = 13,
  parameter int DEV_W   = 3,
  parameter int PLL_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int BYP_A   = 5,
  parameter int BYP_B   = 6,
  localparam int CFG_W  = STRAP_W - DEV_W - PLL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_por,
  input  logic               req_full,
  input  logic               req_norm,
  input  logic               req_local,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               hib_flag,
  input  logic [ADDR_W-1:0]  hib_addr,
  input  logic               ack,
  output logic [STRAP_W-1:0] status_word,
  output logic [DEV_W-1:0]   boot_dev,
  output logic [CFG_W-1:0]   dev_cfg,
  output logic [PLL_W-1:0]   pll_sel,
  output logic [PLL_W-1:0]   ext_cfg,
  output logic               pll_bypass,
  output logic               act_boot,
  output logic               act_resume,
  output logic               act_idle,
  output logic [ADDR_W-1:0]  resume_addr
);

  // Named internal events, also observed by the checker
  logic    latch_ev;
  logic    boot_ev;
  logic    local_ev;
  action_e act;

  bsl_reset_arbiter u_arb (
    .req_por  (req_por),
    .req_full (req_full),
    .req_norm (req_norm),
    .req_local(req_local),
    .latch_ev (latch_ev),
    .boot_ev  (boot_ev),
    .local_ev (local_ev)
  );

  bsl_strap_reg #(.STRAP_W(STRAP_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_en(latch_ev),
    .pins    (strap_pins),
    .word    (status_word)
  );

  bsl_field_decode #(
    .STRAP_W(STRAP_W), .DEV_W(DEV_W), .PLL_W(PLL_W),
    .BYP_A(BYP_A), .BYP_B(BYP_B)
  ) u_dec (
    .word   (status_word),
    .dev    (boot_dev),
    .cfg    (dev_cfg),
    .pll_sel(pll_sel),
    .ext_cfg(ext_cfg),
    .bypass (pll_bypass)
  );

  bsl_action_ctrl #(.ADDR_W(ADDR_W)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .boot_ev (boot_ev),
    .local_ev(local_ev),
    .hib_flag(hib_flag),
    .hib_addr(hib_addr),
    .ack     (ack),
    .act     (act),
    .addr    (resume_addr)
  );

  assign act_idle   = act[0];
  assign act_boot   = act[1];
  assign act_resume = act[2];

endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
  parameter int STRAP_W = 13,
  parameter int DEV_W   = 3,
  parameter int PLL_W   = 3,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_por,
  input logic               req_full,
  input logic               req_norm,
  input logic               req_local,
  input logic [STRAP_W-1:0] strap_pins,
  input logic               hib_flag,
  input logic [ADDR_W-1:0]  hib_addr,
  input logic               ack,
  input logic [STRAP_W-1:0] status_word,
  input logic [DEV_W-1:0]   boot_dev,
  input logic [PLL_W-1:0]   pll_sel,
  input logic [PLL_W-1:0]   ext_cfg,
  input logic               pll_bypass,
  input logic [2:0]         act,
  input logic [ADDR_W-1:0]  resume_addr,
  input logic               latch_ev,
  input logic               boot_ev,
  input logic               local_ev
);

  logic any_req;
  assign any_req = req_por | req_full | req_norm | req_local;

  p_latch_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_por |=> status_word == $past(strap_pins));

  p_latch_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_full |=> status_word == $past(strap_pins));

  p_norm_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_norm && !req_por && !req_full) |=> $stable(status_word) && !act[0]);

  p_local_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_local && !req_por && !req_full && !req_norm) |=> $stable(status_word) && act == 3'b001);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> (boot_dev == DEV_W'(5) || boot_dev == DEV_W'(6)) && pll_sel == '0);

  p_nobypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_bypass |-> ext_cfg == '0);

  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ev && hib_flag) |=> act == 3'b100 && resume_addr == $past(hib_addr));

  p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (local_ev) |-> !latch_ev && !boot_ev);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req && !ack) |=> $stable(act) && $stable(resume_addr));

  p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req && ack) |=> act == 3'b001);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == 1);

  p_addr_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !act[2] |-> resume_addr == '0);

endmodule

bind boot_strap_latch bsl_checker #(
  .STRAP_W(STRAP_W), .DEV_W(DEV_W), .PLL_W(PLL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_por    (req_por),
  .req_full   (req_full),
  .req_norm   (req_norm),
  .req_local  (req_local),
  .strap_pins (strap_pins),
  .hib_flag   (hib_flag),
  .hib_addr   (hib_addr),
  .ack        (ack),
  .status_word(status_word),
  .boot_dev   (boot_dev),
  .pll_sel    (pll_sel),
  .ext_cfg    (ext_cfg),
  .pll_bypass (pll_bypass),
  .act        ({act_resume, act_boot, act_idle}),
  .resume_addr(resume_addr),
  .latch_ev   (latch_ev),
  .boot_ev    (boot_ev),
  .local_ev   (local_ev)
);

// File: tb/boot_strap_latch_tb.sv
module boot_strap_latch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_por = 0, req_full = 0, req_norm = 0, req_local = 0;
  logic [12:0] strap_pins = '0;
  logic        hib_flag = 0;
  logic [31:0] hib_addr = '0;
  logic        ack = 0;
  logic [12:0] status_word;
  logic [2:0]  boot_dev;
  logic [6:0]  dev_cfg;
  logic [2:0]  pll_sel, ext_cfg;
  logic        pll_bypass, act_boot, act_resume, act_idle;
  logic [31:0] resume_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [12:0] m_word = '0;
  logic [2:0]  m_act = 3'b001;   // {resume, boot, idle}
  logic [31:0] m_addr = '0;

  always #10 clk = ~clk;

  boot_strap_latch u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_por(req_por), .req_full(req_full), .req_norm(req_norm), .req_local(req_local),
    .strap_pins(strap_pins), .hib_flag(hib_flag), .hib_addr(hib_addr), .ack(ack),
    .status_word(status_word), .boot_dev(boot_dev), .dev_cfg(dev_cfg),
    .pll_sel(pll_sel), .ext_cfg(ext_cfg), .pll_bypass(pll_bypass),
    .act_boot(act_boot), .act_resume(act_resume), .act_idle(act_idle),
    .resume_addr(resume_addr)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit serial_dev(logic [2:0] d);
    return d inside {3'd5, 3'd6};
  endfunction

  task automatic check_all(string tag_word, string tag_act);
    logic [2:0] d;
    d = m_word[2:0];
    chk(tag_word, 32'(status_word), 32'(m_word));
    chk("R6", {25'd0, dev_cfg}, {25'd0, m_word[9:3]});
    chk("R6", 32'(boot_dev), 32'(d));
    chk("R7", 32'(pll_bypass), 32'(serial_dev(d)));
    chk("R7", 32'(pll_sel), serial_dev(d) ? 32'd0 : 32'(m_word[12:10]));
    chk("R7", 32'(ext_cfg), serial_dev(d) ? 32'(m_word[12:10]) : 32'd0);
    chk(tag_act, 32'({act_resume, act_boot, act_idle}), 32'(m_act));
    chk("R11", 32'($countones({act_resume, act_boot, act_idle})), 32'd1);
    chk("R12", resume_addr, m_addr);
  endtask

  // Drive one cycle of inputs at the falling edge, then compare after the rising edge
  task automatic step(bit p, bit f, bit n, bit l, logic [12:0] pins, bit hib,
                      logic [31:0] ha, bit ak);
    string tw, ta;
    int nreq;
    req_por = p; req_full = f; req_norm = n; req_local = l;
    strap_pins = pins; hib_flag = hib; hib_addr = ha; ack = ak;
    nreq = int'(p) + int'(f) + int'(n) + int'(l);
    tw = p ? "R2" : f ? "R3" : n ? "R4" : l ? "R5" : "R10";
    if (nreq > 1)             ta = "R9";
    else if ((p | f | n) && hib) ta = "R8";
    else                      ta = tw;
    if (p | f) m_word = pins;
    if (p | f | n) begin
      m_act  = hib ? 3'b100 : 3'b010;
      m_addr = hib ? ha : 32'd0;
    end else if (l | ak) begin
      m_act  = 3'b001;
      m_addr = 32'd0;
    end
    @(posedge clk);
    @(negedge clk);
    req_por = 0; req_full = 0; req_norm = 0; req_local = 0; ack = 0;
    check_all(tw, ta);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", "R1");

    // Power-on with a serial-memory device: bypass
    step(1,0,0,0, {3'b101, 7'h2A, 3'd5}, 0, 32'h0, 0);
    // Held without ack
    step(0,0,0,0, 13'h1FFF, 0, 32'h0, 0);
    step(0,0,0,0, 13'h0, 0, 32'h0, 1);           // R10 ack to idle
    step(0,0,1,0, 13'h1ABC, 0, 32'h0, 0);        // R4 keep word
    step(0,1,0,0, {3'b011, 7'h11, 3'd3}, 0, 32'h0, 0); // R3, no bypass
    step(0,0,0,1, 13'h0777, 0, 32'h0, 0);        // R5 local
    step(0,0,0,0, 13'h0, 1, 32'hDEAD_BEEF, 0);   // no request: hib ignored
    step(0,0,1,0, 13'h0, 1, 32'h8000_1000, 0);   // R8 resume
    step(0,0,0,0, 13'h0, 1, 32'h1234_5678, 0);   // R12 addr stable
    step(0,0,0,1, 13'h0, 1, 32'h4444_0000, 1);   // local with hib -> idle
    step(0,0,1,0, {3'b110, 7'h00, 3'd6}, 0, 32'h0, 1); // R10 request beats ack
    step(0,0,1,1, 13'h0, 0, 32'h0, 0);           // R9 normal beats local
    step(0,1,0,1, {3'b001, 7'h7F, 3'd6}, 1, 32'hCAFE_0004, 0); // R9 full beats local
    step(1,1,1,1, {3'b111, 7'h55, 3'd2}, 0, 32'h0, 0); // R9 all
    step(0,0,0,0, 13'h0, 0, 32'h0, 1);

    for (int i = 0; i < 400; i++) begin
      bit p, f, n, l, hb, ak;
      p  = ($urandom % 10) == 0;
      f  = ($urandom % 8) == 0;
      n  = ($urandom % 6) == 0;
      l  = ($urandom % 6) == 0;
      hb = ($urandom % 3) == 0;
      ak = ($urandom % 4) == 0;
      step(p, f, n, l, 13'($urandom), hb, $urandom, ak);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule